// File: doc/BRIEF.md
# Clocked Static RAM with Four-Word Burst Addressing

This block models a synchronous static RAM of byte-wide words. The array is organised as rows and columns. The upper address bits choose a row through a one-hot row decoder, and the lower bits choose a column. The default build uses 16 rows by 128 columns. Setting `ROW_BITS` to 8 gives the full 256 by 128 organisation of 32K bytes. Inputs and outputs are synchronous to one clock. Chip select, write enable and output enable gate each access. Write data and read data use separate 8-bit ports.

An external address is captured with a load strobe. A two-bit burst counter then steps the two lowest internal address bits on every selected cycle. A single address can therefore reach four neighbouring words. The counter offset is added to the captured low bits modulo four. As a result, a burst that starts in the middle of an aligned group of four wraps back to the start of that group. When burst mode is off, the captured address is used unchanged. Read data is registered, and it comes with a valid flag. When that flag is low, the data output is forced to zero to show that the output is not driven.

Top module: `sram_burst_ctrl`

## Requirements
- R1: The address is `ROW_BITS+COL_BITS` bits wide. Bits [AW-1:COL_BITS] select the row and bits [COL_BITS-1:0] select the column. Each location stores its own 8-bit word, independent of all other locations.
- R2: On a rising clock edge where `cs` and `we` are both 1, `din` is written to the current internal address.
- R3: On an edge where `cs`=1, `oe`=1 and `we`=0, the word at the current internal address appears on `dout` after that edge, and `dout_valid` is 1.
- R4: After any other edge (`cs`=0, `oe`=0, or `we`=1), `dout_valid` is 0 and `dout` is 8'h00.
- R5: When `addr_load`=1, `addr` is captured at the edge and the burst count is cleared to 0.
- R6: With `burst_en`=1, the internal address keeps the captured upper bits. Its two low bits are (captured low bits + count) mod 4. Each edge with `cs`=1 advances the count by one mod 4, so the fifth access of a burst returns to the first word.
- R7: With `burst_en`=0, the count is held at 0 and every access uses the captured address unchanged.
- R8: An edge with `cs`=0 leaves the memory contents unchanged and does not advance the count.
- R9: After synchronous active-low reset, `dout`=0, `dout_valid`=0, the count is 0 and the captured address is 0.
- R10: If `addr_load` and an access fall on the same edge, the access uses the old internal address. The next access uses offset 0 of the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select |
| we | input | 1 | Write enable |
| oe | input | 1 | Output enable |
| burst_en | input | 1 | 1 lets the burst counter advance on selected cycles |
| addr_load | input | 1 | Captures `addr` and clears the burst count |
| addr | input | ROW_BITS+COL_BITS | External word address |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data, zero when not valid |
| dout_valid | output | 1 | 1 when `dout` carries read data |

## Verification
The checker assumes that the control inputs are stable and known at every rising edge after reset. It also assumes that the burst count is observed only through its effect on the internal address. Its counter properties therefore compare each edge with the one before it, and they treat `addr_load` as overriding both stepping and clearing. The bench changes every input only on the falling clock edge. It holds `cs`, `we`, `oe`, `burst_en` and `addr_load` at defined levels throughout, and it never writes while reset is active. As a result, the memory is only read at locations the bench has itself written.

// File: rtl/sram_burst_pkg.sv
// Package: shared constants and the access-kind encoding for the burst SRAM.
// Assumes a byte-wide word and a four-word burst group.
package sram_burst_pkg;
    localparam int DATA_W    = 8;
    localparam int BURST_LEN = 4;
    localparam int CNT_W     = $clog2(BURST_LEN);

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } sram_op_e;

    // Adds a burst offset to the low address bits with wrap inside the group.
    function automatic logic [CNT_W-1:0] wrap_low(input logic [CNT_W-1:0] base,
                                                  input logic [CNT_W-1:0] ofs);
        return CNT_W'(base + ofs);
    endfunction
endpackage

// File: rtl/sram_burst_counter.sv
// Module: burst offset counter.
// Clears on a new external address and when bursting is off. Otherwise it
// steps once per selected cycle and wraps at the burst length.
// Assumes a synchronous active-low reset.
module sram_burst_counter
    import sram_burst_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         enable,
    input  logic         step,
    output logic [W-1:0] count
);
    // Updates the burst offset: load and disable clear it, a selected cycle advances it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= '0;
        end else if (!enable) begin
            count <= '0;
        end else if (step) begin
            count <= W'(count + 1'b1);
        end
    end
endmodule

// File: rtl/sram_addr_map.sv
// Module: internal address formation and row/column split.
// Replaces the low address bits with the captured low bits plus the burst
// offset, modulo the burst length. Then splits the result into row and column.
// Assumes COL_BITS is larger than the counter width.
module sram_addr_map
    import sram_burst_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 7,
    parameter int W        = CNT_W,
    localparam int AW      = ROW_BITS + COL_BITS
) (
    input  logic [AW-1:0]       ext_addr,
    input  logic [W-1:0]        offset,
    output logic [ROW_BITS-1:0] row,
    output logic [COL_BITS-1:0] col
);
    logic [AW-1:0] int_addr;

    // Builds the internal address with a wrapped low field.
    always_comb begin
        int_addr = {ext_addr[AW-1:W], wrap_low(ext_addr[W-1:0], offset)};
    end

    assign row = int_addr[AW-1:COL_BITS];
    assign col = int_addr[COL_BITS-1:0];
endmodule

// File: rtl/sram_row_decoder.sv
// Module: one-hot row decoder.
// Drives exactly one select line for the addressed row while enabled, and
// none otherwise.
module sram_row_decoder #(
    parameter int ROW_BITS = 4,
    localparam int ROWS    = 1 << ROW_BITS
) (
    input  logic                en,
    input  logic [ROW_BITS-1:0] row,
    output logic [ROWS-1:0]     sel
);
    // One comparator per row line.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign sel[r] = en && (row == ROW_BITS'(r));
    end
endmodule

// File: rtl/sram_cell_array.sv
// Module: storage array with a registered read port.
// Writes land in the row picked by the one-hot row select, at the addressed
// column. Reads are registered and flagged. A cycle that is not a read drives
// zero with the flag low. Contents are not reset.
module sram_cell_array
    import sram_burst_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 7,
    parameter int DW       = DATA_W,
    localparam int ROWS    = 1 << ROW_BITS,
    localparam int COLS    = 1 << COL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  sram_op_e            op,
    input  logic [ROWS-1:0]     row_sel,
    input  logic [ROW_BITS-1:0] row,
    input  logic [COL_BITS-1:0] col,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic                rvalid
);
    logic [DW-1:0] store [ROWS][COLS];

    // Stores write data into the selected row at the addressed column.
    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (row_sel[r] && (op == OP_WRITE)) begin
                store[r][col] <= wdata;
            end
        end
    end

    // Registers read data and its valid flag; non-read cycles drive zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else if (op == OP_READ) begin
            rdata  <= store[row][col];
            rvalid <= 1'b1;
        end else begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/sram_burst_ctrl.sv
// Module: top of the clocked burst SRAM.
// Captures an external address on a load strobe. Forms the internal address
// from it and a two-bit burst offset, decodes the control pins into one access
// kind, and runs the array.
// Assumes all inputs are synchronous to clk and the reset is active low.
module sram_burst_ctrl
    import sram_burst_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 7,
    localparam int AW      = ROW_BITS + COL_BITS,
    localparam int ROWS    = 1 << ROW_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic              oe,
    input  logic              burst_en,
    input  logic              addr_load,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);
    logic [AW-1:0]       ext_q;
    logic [CNT_W-1:0]    burst_cnt;
    logic [ROW_BITS-1:0] row;
    logic [COL_BITS-1:0] col;
    logic [ROWS-1:0]     row_sel;
    sram_op_e            op;

    // Captures the external address when a new one is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else if (addr_load) begin
            ext_q <= addr;
        end
    end

    // Decodes the control pins into one access kind; write wins over read.
    always_comb begin
        if (!rst_n || !cs) begin
            op = OP_IDLE;
        end else if (we) begin
            op = OP_WRITE;
        end else if (oe) begin
            op = OP_READ;
        end else begin
            op = OP_IDLE;
        end
    end

    sram_burst_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (addr_load),
        .enable (burst_en),
        .step   (cs),
        .count  (burst_cnt)
    );

    sram_addr_map #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .W(CNT_W)) u_map (
        .ext_addr (ext_q),
        .offset   (burst_cnt),
        .row      (row),
        .col      (col)
    );

    sram_row_decoder #(.ROW_BITS(ROW_BITS)) u_dec (
        .en  (op == OP_WRITE),
        .row (row),
        .sel (row_sel)
    );

    sram_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DW(DATA_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .row_sel (row_sel),
        .row     (row),
        .col     (col),
        .wdata   (din),
        .rdata   (dout),
        .rvalid  (dout_valid)
    );
endmodule

// File: rtl/sram_burst_ctrl_chk.sv
// Module: property checker for the burst SRAM, attached with bind.
// Relates the control pins to the read flag and to the burst offset
// from one edge to the next.
module sram_burst_ctrl_chk
    import sram_burst_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              we,
    input logic              oe,
    input logic              burst_en,
    input logic              addr_load,
    input logic [DATA_W-1:0] dout,
    input logic              dout_valid,
    input logic [CNT_W-1:0]  burst_cnt
);
    // A qualified read raises the valid flag after the edge (R3).
    assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && oe && !we) |=> dout_valid);

    // Any other cycle leaves the output flagged off and zero (R4).
    assert_idle_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && oe && !we) |=> (!dout_valid && dout == '0));

    // Loading an address clears the burst offset (R5).
    assert_load_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> (burst_cnt == '0));

    // A selected cycle in burst mode advances the offset by one (R6).
    assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_en && cs && !addr_load) |=> (burst_cnt == CNT_W'($past(burst_cnt) + 1'b1)));

    // Burst mode off keeps the offset at zero (R7).
    assert_no_burst_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_en && !addr_load) |=> (burst_cnt == '0));

    // A deselected cycle holds the offset (R8).
    assert_deselect_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_en && !cs && !addr_load) |=> $stable(burst_cnt));
endmodule

bind sram_burst_ctrl sram_burst_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (cs),
    .we         (we),
    .oe         (oe),
    .burst_en   (burst_en),
    .addr_load  (addr_load),
    .dout       (dout),
    .dout_valid (dout_valid),
    .burst_cnt  (burst_cnt)
);

// File: tb/sram_burst_ctrl_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the burst SRAM. Each task checks its own results.
module sram_burst_ctrl_test;
    localparam int ROW_BITS = 4;
    localparam int COL_BITS = 7;
    localparam int AW       = ROW_BITS + COL_BITS;
    localparam int WORDS    = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n, cs, we, oe, burst_en, addr_load;
    logic [AW-1:0] addr;
    logic [7:0]    din;
    logic [7:0]    dout;
    logic          dout_valid;

    logic [7:0]    model [WORDS];
    int            n_chk = 0;
    int            n_bad = 0;
    bit            finished = 1'b0;

    always #2 clk = ~clk;

    sram_burst_ctrl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .oe(oe),
        .burst_en(burst_en), .addr_load(addr_load), .addr(addr),
        .din(din), .dout(dout), .dout_valid(dout_valid)
    );

    // Internal address reached at burst offset k from base b.
    function automatic logic [AW-1:0] at(input logic [AW-1:0] b, input int k);
        return {b[AW-1:2], 2'(b[1:0] + 2'(k))};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got valid/data %h, expected %h", req, act, exp);
        end
    endtask

    // Drives one cycle from a falling edge; returns at the next falling edge.
    task automatic cycle(input logic c, input logic w, input logic o, input logic b,
                         input logic ld, input logic [AW-1:0] a, input logic [7:0] d);
        cs = c; we = w; oe = o; burst_en = b; addr_load = ld; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
        cs = 1'b0; we = 1'b0; oe = 1'b0; addr_load = 1'b0;
    endtask

    task automatic load(input logic [AW-1:0] a, input logic b);
        cycle(1'b0, 1'b0, 1'b0, b, 1'b1, a, 8'h00);
    endtask

    task automatic wr(input logic b, input logic [AW-1:0] ia, input logic [7:0] d);
        cycle(1'b1, 1'b1, 1'b1, b, 1'b0, '0, d);
        model[ia] = d;
    endtask

    task automatic rd(input string req, input logic b, input logic [AW-1:0] ia);
        cycle(1'b1, 1'b0, 1'b1, b, 1'b0, '0, 8'h00);
        check(req, {dout_valid, dout}, {1'b1, model[ia]});
    endtask

    task automatic t_reset;
        check("R9 reset output", {dout_valid, dout}, 9'h000);
    endtask

    task automatic t_single;
        load(11'h2A5, 1'b0);
        wr(1'b0, 11'h2A5, 8'h3C);
        check("R4 write cycle output", {dout_valid, dout}, 9'h000);
        rd("R2 R3 single read", 1'b0, 11'h2A5);
        rd("R7 no-burst repeat 1", 1'b0, 11'h2A5);
        rd("R7 no-burst repeat 2", 1'b0, 11'h2A5);
    endtask

    task automatic t_rowcol;
        load(11'h291, 1'b0); wr(1'b0, 11'h291, 8'hA1);
        load(11'h311, 1'b0); wr(1'b0, 11'h311, 8'hB2);
        load(11'h292, 1'b0); wr(1'b0, 11'h292, 8'hC3);
        load(11'h291, 1'b0); rd("R1 row5 col11", 1'b0, 11'h291);
        load(11'h311, 1'b0); rd("R1 row6 col11", 1'b0, 11'h311);
        load(11'h292, 1'b0); rd("R1 row5 col12", 1'b0, 11'h292);
    endtask

    task automatic t_burst;
        load(11'h0C6, 1'b1);
        for (int k = 0; k < 4; k++) wr(1'b1, at(11'h0C6, k), 8'h50 + 8'(k));
        load(11'h0C6, 1'b1);
        for (int k = 0; k < 5; k++) rd("R6 burst read wrap", 1'b1, at(11'h0C6, k));
        load(11'h0C4, 1'b0);
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, 8'h00);
        check("R6 wrap lands at group start", {dout_valid, dout}, 9'h152);
    endtask

    task automatic t_reload;
        load(11'h0C6, 1'b1);
        rd("R5 burst offset 0", 1'b1, at(11'h0C6, 0));
        rd("R5 burst offset 1", 1'b1, at(11'h0C6, 1));
        cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'h2A5, 8'h00);
        check("R10 coincident read uses old address", {dout_valid, dout}, {1'b1, model[at(11'h0C6, 2)]});
        rd("R5 R10 reload offset 0", 1'b1, 11'h2A5);
    endtask

    task automatic t_deselect;
        load(11'h0C6, 1'b1);
        rd("R8 offset 0", 1'b1, at(11'h0C6, 0));
        cycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0, 8'hFF);
        check("R4 deselected output", {dout_valid, dout}, 9'h000);
        rd("R8 count held and no write", 1'b1, at(11'h0C6, 1));
    endtask

    task automatic t_gating;
        load(11'h2A5, 1'b0);
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 8'h00);
        check("R4 oe low output", {dout_valid, dout}, 9'h000);
        wr(1'b0, 11'h2A5, 8'h7E);
        check("R4 we high output", {dout_valid, dout}, 9'h000);
        rd("R2 overwrite visible", 1'b0, 11'h2A5);
    endtask

    initial begin
        rst_n = 1'b0; cs = 1'b0; we = 1'b0; oe = 1'b0; burst_en = 1'b0;
        addr_load = 1'b0; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_rowcol();
        t_burst();
        t_reload();
        t_deselect();
        t_gating();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule